// File: doc/BRIEF.md
# Fixed-Frequency Trigger Veto

This block watches a stream of single-cycle trigger pulses and finds trains of triggers that repeat at a nearly constant period. It measures the number of clock cycles between consecutive triggers and compares each interval with the one before it. If the two agree within a programmable tolerance, a match counter goes up. Once the counter reaches a programmable threshold, the block declares a fixed-frequency condition and holds a veto. Only intervals inside a programmable band, from a minimum to a maximum period, take part in this. Slow or fast periodic trains outside the band are left alone, and so are known harmless fixed rates.

What the veto does depends on the operating mode. In run mode the block never removes a trigger, because dropping one would break trigger numbering downstream. It raises a busy request toward the central trigger instead. In stand-alone mode the block removes the offending triggers from its gated trigger output before any numbering happens. In both modes a counter accumulates the number of clock cycles spent vetoing, so the dead time this causes can be read.

The veto is released in two cases: a later interval fails the match, or more than the maximum period passes without any trigger.

Top module: `periodic_trig_veto`

## Requirements
- R1: The period of a trigger is the number of clock cycles since the previous sampled trigger. The first trigger after reset has no period. The period counter saturates at 2^PER_W-1, and a saturated period always counts as out of band, even when the maximum period is programmed to that value.
- R2: A period that is in band and differs from the previous in-band period by no more than `tol_i` (absolute difference) increments the match count. Periods that alternate by exactly the tolerance still match.
- R3: A period shorter than `per_min_i` or longer than `per_max_i` clears the match count and releases the veto. The band limits are themselves in band.
- R4: The veto is set by the trigger whose match raises the count to `match_thr_i` or above. With a constant in-band period, this is trigger number `match_thr_i`+2 counted from the first one in the train.
- R5: An in-band period that differs from the previous one by more than `tol_i` clears the match count and releases the veto in the next cycle.
- R6: In run mode (`standalone_i`=0), `trig_o` always equals `trig_i`, and `busy_o` is high exactly while the veto is held.
- R7: In stand-alone mode (`standalone_i`=1), `busy_o` stays low. A trigger arriving while the veto is held is removed from `trig_o`. The trigger that sets the veto still passes.
- R8: `dead_cnt_o` increases by one for every clock cycle in which the veto is held, in either mode. It saturates at its maximum value and is cleared only by reset.
- R9: If no trigger arrives while the cycles since the last trigger exceed `per_max_i`, the match count and the veto are cleared. The veto is therefore held for `per_max_i`+1 cycles after the last trigger of a train.
- R10: After reset, `busy_o` is low, `dead_cnt_o` is zero and no veto is held.

Counts are given for the bench's setting of `PER_W`=10, `match_thr_i`=3, `tol_i`=2 and a band of 20 to 200 cycles. The requirements above hold for any setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Incoming single-cycle trigger pulse |
| standalone_i | input | 1 | 0 = run mode (raise busy), 1 = stand-alone mode (suppress triggers) |
| per_min_i | input | PER_W | Shortest period that is examined |
| per_max_i | input | PER_W | Longest period that is examined; also the release timeout |
| tol_i | input | PER_W | Largest allowed difference between successive periods |
| match_thr_i | input | CNT_W | Match count that declares the fixed-frequency condition |
| busy_o | output | 1 | Busy request toward the central trigger (run mode) |
| trig_o | output | 1 | Gated trigger |
| dead_cnt_o | output | DT_W | Cycles spent with the veto held |

## Verification
Two events can fall on the same cycle. In one, a trigger arrives while the veto is already held, so a new period is measured in the very cycle that the gated output must drop the trigger. In the other, a trigger completes the threshold while that same trigger must still pass. The stand-alone train rows provoke both. The bench counts the pulses on `trig_o` and expects exactly `match_thr_i`+2 of them however long the train runs. The dead-time check also meets the release timeout in the same run: a held veto must be counted for exactly `per_max_i`+1 cycles.

// File: rtl/ftv_pkg.sv
package ftv_pkg;
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_SOLO = 1'b1
    } mode_e;
endpackage

// File: rtl/ftv_interval.sv
module ftv_interval #(
    parameter int PER_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    output logic [PER_W-1:0] period_o,
    output logic             seen_o
);
    localparam logic [PER_W-1:0] PER_SAT = '1;

    typedef struct packed {
        logic [PER_W-1:0] elapsed;
        logic             seen;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i) begin
            st_d.elapsed = PER_W'(1);
            st_d.seen    = 1'b1;
        end else if (st_q.elapsed != PER_SAT) begin
            st_d.elapsed = st_q.elapsed + PER_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign period_o = st_q.elapsed;
    assign seen_o   = st_q.seen;
endmodule

// File: rtl/ftv_match.sv
module ftv_match #(
    parameter int PER_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic             seen_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [PER_W-1:0] per_min_i,
    input  logic [PER_W-1:0] per_max_i,
    input  logic [PER_W-1:0] tol_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             veto_o
);
    localparam logic [PER_W-1:0] PER_SAT = '1;
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    typedef struct packed {
        logic [PER_W-1:0] prev;
        logic             prev_ok;
        logic [CNT_W-1:0] count;
        logic             veto;
    } st_t;

    st_t st_d, st_q;

    logic             in_band;
    logic [PER_W-1:0] diff;
    logic             close;
    logic [CNT_W-1:0] bump;

    always_comb begin
        in_band = (period_i >= per_min_i) && (period_i <= per_max_i) && (period_i != PER_SAT);
        diff    = (period_i >= st_q.prev) ? (period_i - st_q.prev) : (st_q.prev - period_i);
        close   = st_q.prev_ok && (diff <= tol_i);
        bump    = (st_q.count == CNT_SAT) ? st_q.count : st_q.count + CNT_W'(1);

        st_d = st_q;
        if (trig_i && seen_i) begin
            if (!in_band) begin
                st_d.count   = '0;
                st_d.prev_ok = 1'b0;
                st_d.veto    = 1'b0;
            end else begin
                st_d.prev    = period_i;
                st_d.prev_ok = 1'b1;
                if (close) begin
                    st_d.count = bump;
                    if (bump >= thr_i) st_d.veto = 1'b1;
                end else begin
                    st_d.count = '0;
                    st_d.veto  = 1'b0;
                end
            end
        end else if (!trig_i && (period_i > per_max_i)) begin
            // quiet for longer than the band: the train has ended
            st_d.count   = '0;
            st_d.prev_ok = 1'b0;
            st_d.veto    = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign veto_o = st_q.veto;
endmodule

// File: rtl/ftv_deadtime.sv
module ftv_deadtime #(
    parameter int DT_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            active_i,
    output logic [DT_W-1:0] count_o
);
    localparam logic [DT_W-1:0] DT_SAT = '1;

    typedef struct packed {
        logic [DT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (active_i && (st_q.cnt != DT_SAT)) st_d.cnt = st_q.cnt + DT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/periodic_trig_veto.sv
module periodic_trig_veto #(
    parameter int PER_W = 16,
    parameter int CNT_W = 8,
    parameter int DT_W  = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic             standalone_i,
    input  logic [PER_W-1:0] per_min_i,
    input  logic [PER_W-1:0] per_max_i,
    input  logic [PER_W-1:0] tol_i,
    input  logic [CNT_W-1:0] match_thr_i,
    output logic             busy_o,
    output logic             trig_o,
    output logic [DT_W-1:0]  dead_cnt_o
);
    import ftv_pkg::*;

    mode_e            mode;
    logic [PER_W-1:0] period_w;
    logic             seen_w;
    logic             veto_w;

    assign mode = mode_e'(standalone_i);

    ftv_interval #(.PER_W(PER_W)) u_interval (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trig_i   (trig_i),
        .period_o (period_w),
        .seen_o   (seen_w)
    );

    ftv_match #(.PER_W(PER_W), .CNT_W(CNT_W)) u_match (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .trig_i    (trig_i),
        .seen_i    (seen_w),
        .period_i  (period_w),
        .per_min_i (per_min_i),
        .per_max_i (per_max_i),
        .tol_i     (tol_i),
        .thr_i     (match_thr_i),
        .veto_o    (veto_w)
    );

    ftv_deadtime #(.DT_W(DT_W)) u_dead (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (veto_w),
        .count_o  (dead_cnt_o)
    );

    assign busy_o = veto_w && (mode == MODE_RUN);
    assign trig_o = trig_i && !(veto_w && (mode == MODE_SOLO));
endmodule

// File: rtl/ftv_checks.sv
module ftv_checks #(
    parameter int PER_W = 16,
    parameter int DT_W  = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             trig_i,
    input logic             standalone_i,
    input logic [PER_W-1:0] per_min_i,
    input logic [PER_W-1:0] per_max_i,
    input logic             busy_o,
    input logic             trig_o,
    input logic [DT_W-1:0]  dead_cnt_o,
    input logic [PER_W-1:0] period,
    input logic             veto
);
    localparam logic [DT_W-1:0] DT_SAT = '1;

    p_run_passthru_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !standalone_i |-> (trig_o == trig_i));

    p_solo_no_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standalone_i |-> !busy_o);

    p_solo_suppress_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (standalone_i && veto) |-> !trig_o);

    p_veto_needs_trig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(veto) |-> $past(trig_i));

    p_short_period_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && (period < per_min_i)) |=> !veto);

    p_timeout_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (veto && !trig_i && (period > per_max_i)) |=> !veto);

    p_dead_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((dead_cnt_o == $past(dead_cnt_o)) || (dead_cnt_o == $past(dead_cnt_o) + DT_W'(1))));

    p_dead_counts_veto_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (veto && (dead_cnt_o != DT_SAT)) |=> (dead_cnt_o == $past(dead_cnt_o) + DT_W'(1)));
endmodule

bind periodic_trig_veto ftv_checks #(.PER_W(PER_W), .DT_W(DT_W)) u_checks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (trig_i),
    .standalone_i (standalone_i),
    .per_min_i    (per_min_i),
    .per_max_i    (per_max_i),
    .busy_o       (busy_o),
    .trig_o       (trig_o),
    .dead_cnt_o   (dead_cnt_o),
    .period       (period_w),
    .veto         (veto_w)
);

// File: tb/periodic_trig_veto_tb.sv
module periodic_trig_veto_tb;
    localparam int PER_W = 10;
    localparam int CNT_W = 8;
    localparam int DT_W  = 32;
    localparam int PMIN  = 20;
    localparam int PMAX  = 200;
    localparam int TOL   = 2;
    localparam int THR   = 3;
    localparam int NROWS = 9;

    // {stand-alone, period, trigger count}
    localparam logic [24:0] ROWS [NROWS] = '{
        {1'b0, 16'd50,  8'd8},
        {1'b0, 16'd50,  8'd4},
        {1'b0, 16'd50,  8'd5},
        {1'b0, 16'd10,  8'd10},
        {1'b0, 16'd250, 8'd6},
        {1'b0, 16'd20,  8'd6},
        {1'b0, 16'd200, 8'd6},
        {1'b1, 16'd60,  8'd8},
        {1'b1, 16'd19,  8'd8}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig = 1'b0;
    logic             solo = 1'b0;
    logic [PER_W-1:0] pmin = PER_W'(PMIN);
    logic [PER_W-1:0] pmax = PER_W'(PMAX);
    logic [PER_W-1:0] tol  = PER_W'(TOL);
    logic [CNT_W-1:0] thr  = CNT_W'(THR);
    logic             busy;
    logic             trig_out;
    logic [DT_W-1:0]  dead;

    int runs = 0;
    int fails = 0;
    int passed = 0;

    always #5 clk = ~clk;

    periodic_trig_veto #(.PER_W(PER_W), .CNT_W(CNT_W), .DT_W(DT_W)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .trig_i       (trig),
        .standalone_i (solo),
        .per_min_i    (pmin),
        .per_max_i    (pmax),
        .tol_i        (tol),
        .match_thr_i  (thr),
        .busy_o       (busy),
        .trig_o       (trig_out),
        .dead_cnt_o   (dead)
    );

    task automatic check(input string req, input longint act, input longint exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse();
        @(negedge clk);
        trig = 1'b1;
        #1;
        if (trig_out) passed++;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic gap_pulse(input int p);
        repeat (p - 2) @(negedge clk);
        pulse();
    endtask

    task automatic train(input int p, input int n);
        pulse();
        for (int i = 1; i < n; i++) gap_pulse(p);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        runs++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R10: reset state
        check("R10 busy after reset", busy, 0);
        check("R10 dead count after reset", dead, 0);

        // table of constant-period trains
        for (int r = 0; r < NROWS; r++) begin
            logic sa;
            int p, n;
            bit band, veto;
            int exp_pass;
            sa = ROWS[r][24];
            p  = int'(ROWS[r][23:8]);
            n  = int'(ROWS[r][7:0]);
            band = (p >= PMIN) && (p <= PMAX);
            veto = band && ((n - 2) >= THR);
            exp_pass = (sa && veto) ? THR + 2 : n;
            solo = sa;
            passed = 0;
            train(p, n);
            idle(2);
            // R3 R4 R6 R7: busy only for in-band trains that reach the threshold in run mode
            check($sformatf("R4/R3/R6 busy row %0d", r), busy, (veto && !sa) ? 1 : 0);
            // R6 R7: gated trigger count
            check($sformatf("R7/R6 passed triggers row %0d", r), passed, exp_pass);
            idle(PMAX + 60);
            // R9: released after quiet time
            check($sformatf("R9 busy released row %0d", r), busy, 0);
        end
        solo = 1'b0;

        // R2: periods alternating by exactly the tolerance still match
        pulse();
        gap_pulse(50); gap_pulse(52); gap_pulse(50); gap_pulse(52); gap_pulse(50);
        idle(2);
        check("R2 tolerance-edge train vetoes", busy, 1);
        idle(PMAX + 60);

        // R2: a difference one beyond the tolerance never builds a count
        pulse();
        gap_pulse(50); gap_pulse(53); gap_pulse(50); gap_pulse(53); gap_pulse(50); gap_pulse(53);
        idle(2);
        check("R2 varied train ignored", busy, 0);
        idle(PMAX + 60);

        // R5: mismatching in-band period releases the veto
        train(50, 6);
        idle(2);
        check("R5 veto before mismatch", busy, 1);
        gap_pulse(80);
        idle(1);
        check("R5 veto after mismatch", busy, 0);
        idle(PMAX + 60);

        // R9: veto held exactly PMAX+1 cycles after the last trigger
        train(50, 6);
        idle(PMAX - 6);
        check("R9 veto held before timeout", busy, 1);
        idle(16);
        check("R9 veto dropped after timeout", busy, 0);

        // R8: dead-time count equals held cycles
        do_reset();
        train(50, 5);
        idle(PMAX + 60);
        check("R8 dead count after one veto", dead, PMAX + 1);
        // R8: counted in stand-alone mode too
        solo = 1'b1;
        train(50, 5);
        idle(PMAX + 60);
        check("R8 dead count stand-alone", dead, 2 * (PMAX + 1));
        solo = 1'b0;

        // R1: saturated period is out of band even with max at full scale
        pmax = '1;
        do_reset();
        pulse();
        for (int i = 0; i < 5; i++) gap_pulse(1100);
        idle(2);
        check("R1 saturated periods ignored", busy, 0);
        // R1: a long but unsaturated period at full-scale max is in band
        train(1000, 6);
        idle(2);
        check("R1 long in-band train vetoes", busy, 1);

        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule